// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

This block sits between a 32-bit load/store port and a narrower bus that is either 8 or 16 bits wide. It takes one request at a time. Each request carries a byte address, an access size (byte, halfword or word), a direction and write data. The block turns the request into a series of bus cycles that each fit the bus. Data may sit at any byte address. A misaligned halfword or word is split into extra cycles and never raises a fault.

The cycles are issued lowest address first. Each cycle carries its own address, a size code and byte enables. On writes, the matching bytes of the write data are steered onto the bus lanes chosen by the cycle address. On reads, each returned slice is placed into the little-endian 32-bit result. A one-cycle done pulse marks the end of a request. Each cycle waits for a bus acknowledge, so the bus may insert any number of wait cycles.

Top module: `misalign_splitter`

## Requirements
- R1: Read data is little-endian. Result bits 7:0 hold the byte at the request address, and bits 8k+7:8k hold the byte at address plus k. Result bytes beyond the access size read as zero.
- R2: Sub-cycles go upward through memory. The first cycle uses the request address. Each later cycle's address is the previous address plus the byte count of the previous cycle: 1 for size code 0, 2 for size code 1.
- R3: On a 16-bit bus, a halfword at an odd address is issued as two byte cycles.
- R4: On a 16-bit bus, a word with address bit 0 set is issued as three cycles in this order: byte, halfword, byte.
- R5: On a 16-bit bus, a word at address bits 10 or 00 is issued as two halfword cycles. An even halfword is one halfword cycle, and a byte is one byte cycle.
- R6: With the 8-bit setting (bus_narrow_i=1), every access is issued as single-byte cycles, as many as the access size. These cycles use lane 0 only (byte enable 01, data on bits 7:0). The width setting and the region select are sampled when the request is accepted. Changes to them during a request have no effect on it.
- R7: When periph_sel_i=1, the bus is treated as 16 bits wide, whatever the value of bus_narrow_i.
- R8: The bus size code is 0 for a byte cycle and 1 for a halfword cycle. On a 16-bit bus, the byte enables are:

  | Cycle | bus_be_o | Lane used |
  |---|---|---|
  | Byte at an even address | 01 | bits 7:0 |
  | Byte at an odd address | 10 | bits 15:8 |
  | Halfword (always at an even address) | 11 | both lanes |

- R9: On a write, bus_write_o is 1. Each enabled lane carries the write-data byte whose index is the cycle's byte offset from the request address, plus the lane position within the cycle.
- R10: A request is taken only while req_ready_o is high. req_ready_o is high only when the block is idle. A request that arrives while the block is busy or completing is ignored.
- R11: done_o is high for exactly one cycle, in the cycle after the acknowledge of the last sub-cycle. rdata_o is valid in that cycle, and bus_valid_o is low in it.
- R12: While bus_valid_o is high and bus_ack_i is low, the block holds the address, size, byte enables, direction and write data of the current cycle. The next sub-cycle starts only after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle; a request is taken this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_narrow_i | input | 1 | 1 selects the 8-bit bus, 0 selects the 16-bit bus |
| periph_sel_i | input | 1 | Peripheral region; forces the 16-bit bus |
| bus_valid_o | output | 1 | Bus cycle active |
| bus_addr_o | output | ADDR_W | Byte address of the current cycle |
| bus_size_o | output | 2 | 0 byte, 1 halfword |
| bus_be_o | output | 2 | Lane enables, bit 0 for bits 7:0 |
| bus_write_o | output | 1 | Cycle direction |
| bus_wdata_o | output | 16 | Write data lanes |
| bus_ack_i | input | 1 | Current cycle complete |
| bus_rdata_i | input | 16 | Read data lanes, sampled together with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Merged read result |

## Verification
The bench runs every size at all four address alignments under each width setting, for both reads and writes, with random wait cycles. It drives the unused read lane with junk so that a lane-selection error shows up. A splitter that treated an odd word as two halfwords, or issued the high part first, would show a wrong address or size code on some sub-cycle. A merge that took a byte from the wrong lane, or stored it at the wrong offset, would return a corrupted result. The bench also flips the width inputs and presents a second request while a request is in progress. A block that re-sampled the width, or accepted a request while busy, would issue a cycle sequence that differs from the expected one.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
  localparam int WORD_W     = 32;
  localparam int BUS_W      = 16;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BUS_BYTES  = BUS_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES) + 1;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} split_state_e;

  function automatic logic [OFF_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return OFF_W'(1);
      2'd1:    return OFF_W'(2);
      default: return OFF_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/split_planner.sv
// Picks the shape of the next sub-cycle from the running address and the bytes left
module split_planner
  import misalign_pkg::*;
(
  input  logic             addr_lsb_i,
  input  logic             narrow_i,
  input  logic [OFF_W-1:0] rem_i,
  output logic             two_o,
  output logic             hi_o,
  output logic [1:0]       be_o,
  output logic [1:0]       size_o
);
  always_comb begin
    two_o  = !narrow_i && !addr_lsb_i && (rem_i >= OFF_W'(2));
    hi_o   = !narrow_i && addr_lsb_i;
    be_o   = two_o ? 2'b11 : (hi_o ? 2'b10 : 2'b01);
    size_o = two_o ? SZ_HALF : SZ_BYTE;
  end
endmodule

// File: rtl/write_lane_mux.sv
module write_lane_mux
  import misalign_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        off_i,
  input  logic              two_i,
  input  logic              hi_i,
  output logic [BUS_W-1:0]  lanes_o
);
  logic [1:0] off_nx;
  logic [7:0] b_lo, b_nx;

  always_comb begin
    off_nx = off_i + 2'd1;
    b_lo   = wdata_i[{off_i, 3'b000} +: 8];
    b_nx   = wdata_i[{off_nx, 3'b000} +: 8];
    if (two_i)     lanes_o = {b_nx, b_lo};
    else if (hi_i) lanes_o = {b_lo, 8'h00};
    else           lanes_o = {8'h00, b_lo};
  end
endmodule

// File: rtl/read_merge.sv
// Accumulates returned lanes into the little-endian result, one register per result byte
module read_merge
  import misalign_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              two_i,
  input  logic              hi_i,
  input  logic [BUS_W-1:0]  lanes_i,
  output logic [WORD_W-1:0] data_o
);
  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_byte
    logic       hit_first, hit_second;
    logic [7:0] src, byte_q;

    assign hit_first  = (off_i == OFF_W'(j));
    assign hit_second = two_i && ((off_i + OFF_W'(1)) == OFF_W'(j));
    assign src        = hit_first ? (hi_i ? lanes_i[15:8] : lanes_i[7:0]) : lanes_i[15:8];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 byte_q <= 8'h00;
      else if (clear_i)                            byte_q <= 8'h00;
      else if (capture_i && (hit_first || hit_second)) byte_q <= src;
    end

    assign data_o[8*j +: 8] = byte_q;
  end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import misalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic                 req_write_i,
  input  logic [WORD_W-1:0]    req_wdata_i,
  input  logic                 bus_narrow_i,
  input  logic                 periph_sel_i,
  output logic                 bus_valid_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [1:0]           bus_size_o,
  output logic [BUS_BYTES-1:0] bus_be_o,
  output logic                 bus_write_o,
  output logic [BUS_W-1:0]     bus_wdata_o,
  input  logic                 bus_ack_i,
  input  logic [BUS_W-1:0]     bus_rdata_i,
  output logic                 done_o,
  output logic [WORD_W-1:0]    rdata_o
);
  split_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q, rem_q, len;
  logic [WORD_W-1:0] wdata_q;
  logic              write_q, narrow_q;
  logic              accept, step, last;
  logic              chunk_two, lane_hi;
  logic [1:0]        be, size;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign step   = (state_q == ST_BUSY) && bus_ack_i;
  assign len    = chunk_two ? OFF_W'(2) : OFF_W'(1);
  assign last   = (rem_q <= len);

  split_planner u_planner (
    .addr_lsb_i (addr_q[0]),
    .narrow_i   (narrow_q),
    .rem_i      (rem_q),
    .two_o      (chunk_two),
    .hi_o       (lane_hi),
    .be_o       (be),
    .size_o     (size)
  );

  write_lane_mux u_wmux (
    .wdata_i (wdata_q),
    .off_i   (off_q[1:0]),
    .two_i   (chunk_two),
    .hi_i    (lane_hi),
    .lanes_o (bus_wdata_o)
  );

  read_merge u_merge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .capture_i (step),
    .off_i     (off_q),
    .two_i     (chunk_two),
    .hi_i      (lane_hi),
    .lanes_i   (bus_rdata_i),
    .data_o    (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      off_q    <= '0;
      rem_q    <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      narrow_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_BUSY;
          addr_q   <= req_addr_i;
          off_q    <= '0;
          rem_q    <= size_bytes(req_size_i);
          wdata_q  <= req_wdata_i;
          write_q  <= req_write_i;
          narrow_q <= bus_narrow_i && !periph_sel_i;
        end
        ST_BUSY: if (bus_ack_i) begin
          addr_q <= addr_q + ADDR_W'(len);
          off_q  <= off_q + len;
          rem_q  <= rem_q - len;
          if (last) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign bus_valid_o = (state_q == ST_BUSY);
  assign bus_addr_o  = addr_q;
  assign bus_size_o  = size;
  assign bus_be_o    = be;
  assign bus_write_o = write_q;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/split_checker.sv
module split_checker
  import misalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_ready_o,
  input logic                 bus_valid_o,
  input logic [ADDR_W-1:0]    bus_addr_o,
  input logic [1:0]           bus_size_o,
  input logic [BUS_BYTES-1:0] bus_be_o,
  input logic                 bus_write_o,
  input logic [BUS_W-1:0]     bus_wdata_o,
  input logic                 bus_ack_i,
  input logic                 done_o
);
  p_hold_in_wait_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ack_i) |=> (bus_valid_o && $stable(bus_addr_o) && $stable(bus_size_o)
      && $stable(bus_be_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

  p_addr_climbs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ack_i) |=> (!bus_valid_o ||
      bus_addr_o == $past(bus_addr_o) + (($past(bus_size_o) == 2'd1) ? ADDR_W'(2) : ADDR_W'(1))));

  p_done_follows_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_valid_o && bus_ack_i));

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bus_valid_o && !done_o));

  p_be_shape_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> ((bus_size_o == 2'd1) ? (bus_be_o == 2'b11 && !bus_addr_o[0])
                                          : ($countones(bus_be_o) == 1)));

  p_upper_lane_odd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_be_o == 2'b10) |-> bus_addr_o[0]);
endmodule

bind misalign_splitter split_checker #(.ADDR_W(ADDR_W)) u_split_checker (.*);

// File: tb/tb_misalign_splitter.sv
module tb_misalign_splitter;
  import misalign_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        bus_narrow, periph_sel;
  logic        bus_valid, bus_write, bus_ack, done;
  logic [31:0] bus_addr, rdata;
  logic [1:0]  bus_size, bus_be;
  logic [15:0] bus_wdata, bus_rdata;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  misalign_splitter #(.ADDR_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .bus_narrow_i(bus_narrow), .periph_sel_i(periph_sel),
    .bus_valid_o(bus_valid), .bus_addr_o(bus_addr), .bus_size_o(bus_size),
    .bus_be_o(bus_be), .bus_write_o(bus_write), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .done_o(done), .rdata_o(rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd7;
    return t + 8'h3C;
  endfunction

  logic [31:0] q_addr[$];
  logic [1:0]  q_size[$];
  logic [1:0]  q_be[$];
  logic [15:0] q_wd[$];

  task automatic run_req(input logic [1:0] sz, input logic [1:0] lo, input logic wr,
                         input logic narrow, input logic periph);
    logic [31:0] base, wd, exp_r;
    bit          wide;
    int          lens[$];
    int          nb, o, waits;
    string       tag;
    bit          first, held;

    base = 32'h1000_0100 | {30'd0, lo};
    wd   = $urandom;
    wide = periph || !narrow;
    nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (!wide) begin
      tag = "R6";
      repeat (nb) lens.push_back(1);
    end else begin
      tag = periph && narrow ? "R7" : "R5";
      case (sz)
        2'd0: lens.push_back(1);
        2'd1: if (lo[0]) begin lens.push_back(1); lens.push_back(1); if (!(periph && narrow)) tag = "R3"; end
              else lens.push_back(2);
        default: if (lo[0]) begin
                   lens.push_back(1); lens.push_back(2); lens.push_back(1);
                   if (!(periph && narrow)) tag = "R4";
                 end else begin lens.push_back(2); lens.push_back(2); end
      endcase
    end
    o = 0;
    foreach (lens[k]) begin
      q_addr.push_back(base + o);
      q_size.push_back(lens[k] == 2 ? 2'd1 : 2'd0);
      if (lens[k] == 2) begin
        q_be.push_back(2'b11);
        q_wd.push_back({wd[8*(o+1) +: 8], wd[8*o +: 8]});
      end else if (wide && ((base[0] + o) % 2 == 1)) begin
        q_be.push_back(2'b10);
        q_wd.push_back({wd[8*o +: 8], 8'h00});
      end else begin
        q_be.push_back(2'b01);
        q_wd.push_back({8'h00, wd[8*o +: 8]});
      end
      o += lens[k];
    end

    @(negedge clk);
    check(req_ready == 1'b1, "R10", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = base; req_size = sz; req_write = wr; req_wdata = wd;
    bus_narrow = narrow; periph_sel = periph;
    @(negedge clk);
    first = 1'b1; held = 1'b0; waits = $urandom_range(0, 2);
    while (q_addr.size() > 0) begin
      if (first) begin
        // busy-time request and width flip must be ignored (R10, R6)
        req_valid = 1'b1; req_addr = 32'hDEAD_BEE1; req_size = 2'd2;
        bus_narrow = ~narrow; periph_sel = ~periph;
      end else begin
        req_valid = 1'b0; bus_narrow = narrow; periph_sel = periph;
      end
      first = 1'b0;
      if (wide) bus_rdata = {mem_b({q_addr[0][31:1], 1'b1}), mem_b({q_addr[0][31:1], 1'b0})};
      else      bus_rdata = {8'hEE, mem_b(q_addr[0])};
      check(bus_valid == 1'b1, "R2", {31'd0, bus_valid}, 32'd1);
      check(req_ready == 1'b0, "R10", {31'd0, req_ready}, 32'd0);
      check(bus_addr == q_addr[0], held ? "R12" : "R2", bus_addr, q_addr[0]);
      check(bus_size == q_size[0], tag, {30'd0, bus_size}, {30'd0, q_size[0]});
      check(bus_be == q_be[0], "R8", {30'd0, bus_be}, {30'd0, q_be[0]});
      check(bus_write == wr, "R9", {31'd0, bus_write}, {31'd0, wr});
      if (wr)
        check((bus_wdata & {{8{q_be[0][1]}}, {8{q_be[0][0]}}}) == q_wd[0], "R9",
              {16'd0, bus_wdata}, {16'd0, q_wd[0]});
      check(done == 1'b0, "R11", {31'd0, done}, 32'd0);
      if (waits == 0) bus_ack = 1'b1;
      else begin bus_ack = 1'b0; waits--; end
      @(negedge clk);
      if (bus_ack) begin
        void'(q_addr.pop_front()); void'(q_size.pop_front());
        void'(q_be.pop_front());   void'(q_wd.pop_front());
        held = 1'b0; waits = $urandom_range(0, 2);
      end else held = 1'b1;
    end
    bus_ack = 1'b0; req_valid = 1'b0; bus_narrow = narrow; periph_sel = periph;
    check(done == 1'b1, "R11", {31'd0, done}, 32'd1);
    check(bus_valid == 1'b0, "R11", {31'd0, bus_valid}, 32'd0);
    if (!wr) begin
      exp_r = '0;
      for (int i = 0; i < nb; i++) exp_r[8*i +: 8] = mem_b(base + i);
      check(rdata == exp_r, "R1", rdata, exp_r);
    end
    @(negedge clk);
    check(done == 1'b0, "R11", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; bus_narrow = 1'b0; periph_sel = 1'b0; bus_ack = 1'b0; bus_rdata = '0;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R10", {31'd0, req_ready}, 32'd1);
    check(bus_valid == 1'b0, "R10", {31'd0, bus_valid}, 32'd0);
    check(done == 1'b0, "R11", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    for (int mode = 0; mode < 3; mode++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 3; s++)
          for (int a = 0; a < 4; a++)
            run_req(2'(s), 2'(a), w[0], mode != 0, mode == 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule